// File: doc/BRIEF.md
# Sticky Fault and Reset-Cause Status Register with Driver Shutdown

This block records supply, clock, temperature and reset events as sticky flags in one 8-bit status word. Each event arrives as a single-cycle pulse and sets its own flag. The flag stays set until software writes 1 to that bit over a plain register bus. The word can be read at any time, and a read has no side effects.

The block also gates the power-driver enable. Charge-pump voltage errors and over-temperature events always force the drivers off. Overvoltage and undervoltage events force them off only when the matching protection-enable input is 1. A forced shutdown is held. The drivers come back only after software clears every flag that caused the trip and then takes the enable request low and high again.

The register bus is a single-cycle control path: a write or read takes effect in the cycle that `bus_sel` is high. There is no back-pressure, so it needs no valid/ready handshake. The event, protection and enable pins are plain level or pulse signals.

Top module: `fault_status_reg`

## Requirements
- R1: After the power-on reset (`rst_n` low), the status word at address 0 reads 0x01, and `drv_en` follows `drv_en_req`.
- R2: Each event pulse sets its flag at the next clock edge. The bit positions are: 7 oscillator failure, 6 charge-pump error, 5 overvoltage, 4 undervoltage, 3 over-temperature, 2 watchdog system reset, 1 watchdog MCU reset, 0 power-on reset.
- R3: Writing to address 0 clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R4: If a flag's event and a write-1 to that flag land in the same cycle, the flag stays 1.
- R5: A charge-pump error or an over-temperature event drives `drv_en` low from the next cycle on, whatever the protection inputs are and whether or not the drivers are already enabled.
- R6: An overvoltage event drives `drv_en` low only if `ov_prot_en` is 1 in the event cycle. An undervoltage event does the same only if `uv_prot_en` is 1. When the matching input is 0, only the flag is set.
- R7: A shutdown is held. It ends only at a clock edge where `drv_en_req` is 0 and every flag that caused it has been cleared. After that, `drv_en` follows the request again.
- R8: Reads return the current flags and change nothing. A read at any address other than 0 returns 0, and a write to any other address has no effect.
- R9: A cycle with `warm_rst_n` low clears bits 7..3 and bit 1. It keeps the watchdog system flag (bit 2) and the power-on flag (bit 0).
- R10: When no shutdown is held, `drv_en` equals `drv_en_req`. Oscillator, watchdog and power-on flags never affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_n | input | 1 | Synchronous warm reset of the non-persistent flags, active low |
| ev_osc_fail | input | 1 | Pulse: low-frequency clock lost |
| ev_cp_err | input | 1 | Pulse: charge-pump voltage out of range |
| ev_ov | input | 1 | Pulse: overvoltage |
| ev_uv | input | 1 | Pulse: undervoltage |
| ev_ot | input | 1 | Pulse: over-temperature |
| ev_wdt_sys | input | 1 | Pulse: watchdog system reset issued |
| ev_wdt_mcu | input | 1 | Pulse: watchdog MCU reset issued |
| ev_por | input | 1 | Pulse: power-on reset seen |
| ov_prot_en | input | 1 | Overvoltage shuts the drivers down when 1 |
| uv_prot_en | input | 1 | Undervoltage shuts the drivers down when 1 |
| drv_en_req | input | 1 | Driver enable request from software |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data (1 = clear that flag) |
| bus_rdata | output | 8 | Read data |
| drv_en | output | 1 | Gated driver enable |

## Verification
The hardest situations to reach are a same-cycle collision of an event with a write-1 to the same bit, and the release of a held shutdown. The bench drives an event pulse and a clearing write in one cycle to hit the collision. For the release, it steps through three states in order: the request toggled while the causing flag is still set, then the flag cleared while the request stays high, and then the request toggled again. It also sends a charge-pump error while the request is low, which shows that the block trips in the act of enabling as well as while the drivers are running.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int FLAG_W = 8;
  localparam int B_OSC  = 7;
  localparam int B_CP   = 6;
  localparam int B_OV   = 5;
  localparam int B_UV   = 4;
  localparam int B_OT   = 3;
  localparam int B_WSYS = 2;
  localparam int B_WMCU = 1;
  localparam int B_POR  = 0;
  localparam int N_TRIP = 4;
  typedef logic [FLAG_W-1:0] flag_vec_t;
  typedef logic [N_TRIP-1:0] trip_vec_t;
endpackage

// File: rtl/fsr_flag_bank.sv
module fsr_flag_bank
  import fsr_pkg::*;
#(
  parameter flag_vec_t RST_VAL   = 8'h01,
  parameter flag_vec_t WARM_KEEP = 8'h05
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      warm_rst_n,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  output flag_vec_t flags
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    localparam bit KEEP = WARM_KEEP[i];
    logic warm_clr;
    assign warm_clr = !warm_rst_n && !KEEP;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags[i] <= RST_VAL[i];
      else if (set_vec[i])  flags[i] <= 1'b1;
      else if (clr_vec[i])  flags[i] <= 1'b0;
      else if (warm_clr)    flags[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flags[i]); // R3
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_vec[i] && !clr_vec[i] && warm_rst_n) |=> $stable(flags[i])); // R2
  end
endmodule

// File: rtl/fsr_bus_decode.sv
module fsr_bus_decode
  import fsr_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 0
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  flag_vec_t         bus_wdata,
  input  flag_vec_t         flags,
  output flag_vec_t         clr_vec,
  output flag_vec_t         bus_rdata
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STAT_ADDR);
  logic hit;
  assign hit       = bus_sel && (bus_addr == HIT_ADDR);
  assign clr_vec   = (hit && bus_wr) ? bus_wdata : '0;
  assign bus_rdata = (hit && !bus_wr) ? flags : '0;
endmodule

// File: rtl/fsr_shutdown_ctrl.sv
module fsr_shutdown_ctrl
  import fsr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ev_cp_err,
  input  logic      ev_ov,
  input  logic      ev_uv,
  input  logic      ev_ot,
  input  logic      ov_prot_en,
  input  logic      uv_prot_en,
  input  logic      drv_en_req,
  input  flag_vec_t flags,
  output logic      drv_en
);
  trip_vec_t trip_vec, cause_q, resp_flags;
  logic shut_q, trip_any, release_ok;

  assign trip_vec   = {ev_cp_err, ev_ov && ov_prot_en, ev_uv && uv_prot_en, ev_ot};
  assign resp_flags = {flags[B_CP], flags[B_OV], flags[B_UV], flags[B_OT]};
  assign trip_any   = |trip_vec;
  assign release_ok = shut_q && !(|(cause_q & resp_flags)) && !drv_en_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shut_q  <= 1'b0;
      cause_q <= '0;
    end else if (trip_any) begin
      shut_q  <= 1'b1;
      cause_q <= cause_q | trip_vec;
    end else if (release_ok) begin
      shut_q  <= 1'b0;
      cause_q <= '0;
    end
  end

  assign drv_en = drv_en_req && !shut_q;

  AST_TRIP_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    trip_any |=> !drv_en); // R5
  AST_SHUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && (|(cause_q & resp_flags))) |=> shut_q); // R7
  AST_SHUT_HELD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && drv_en_req) |=> !drv_en || $past(!shut_q)); // R7
  AST_UNPROT_OV_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!shut_q && ev_ov && !ov_prot_en && !ev_cp_err && !ev_ot && !(ev_uv && uv_prot_en))
    |=> !shut_q); // R6
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fsr_pkg::*;
#(
  parameter int        ADDR_W    = 4,
  parameter int        STAT_ADDR = 0,
  parameter flag_vec_t RST_VAL   = 8'h01,
  parameter flag_vec_t WARM_KEEP = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst_n,
  input  logic              ev_osc_fail,
  input  logic              ev_cp_err,
  input  logic              ev_ov,
  input  logic              ev_uv,
  input  logic              ev_ot,
  input  logic              ev_wdt_sys,
  input  logic              ev_wdt_mcu,
  input  logic              ev_por,
  input  logic              ov_prot_en,
  input  logic              uv_prot_en,
  input  logic              drv_en_req,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              drv_en
);
  flag_vec_t set_vec, clr_vec, flags;

  assign set_vec = {ev_osc_fail, ev_cp_err, ev_ov, ev_uv,
                    ev_ot, ev_wdt_sys, ev_wdt_mcu, ev_por};

  fsr_flag_bank #(.RST_VAL(RST_VAL), .WARM_KEEP(WARM_KEEP)) u_bank (
    .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
    .set_vec(set_vec), .clr_vec(clr_vec), .flags(flags)
  );

  fsr_bus_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR)) u_bus (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .flags(flags), .clr_vec(clr_vec),
    .bus_rdata(bus_rdata)
  );

  fsr_shutdown_ctrl u_shut (
    .clk(clk), .rst_n(rst_n), .ev_cp_err(ev_cp_err), .ev_ov(ev_ov),
    .ev_uv(ev_uv), .ev_ot(ev_ot), .ov_prot_en(ov_prot_en),
    .uv_prot_en(uv_prot_en), .drv_en_req(drv_en_req), .flags(flags),
    .drv_en(drv_en)
  );

  AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (bus_addr != ADDR_W'(STAT_ADDR))) |-> (bus_rdata == 8'h00)); // R8
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !(|set_vec) && warm_rst_n) |=> $stable(flags)); // R8
  AST_WARM_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!warm_rst_n && flags[B_WSYS] && flags[B_POR]) |=> (flags[B_WSYS] && flags[B_POR])); // R9
endmodule

// File: tb/fault_status_reg_tb_top.sv
module fault_status_reg_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0, warm_rst_n = 1'b1;
  logic [7:0] ev = '0;
  logic       ov_prot_en = 1'b0, uv_prot_en = 1'b0, drv_en_req = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       drv_en;

  fault_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .warm_rst_n(warm_rst_n),
    .ev_osc_fail(ev[7]), .ev_cp_err(ev[6]), .ev_ov(ev[5]), .ev_uv(ev[4]),
    .ev_ot(ev[3]), .ev_wdt_sys(ev[2]), .ev_wdt_mcu(ev[1]), .ev_por(ev[0]),
    .ov_prot_en(ov_prot_en), .uv_prot_en(uv_prot_en), .drv_en_req(drv_en_req),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_en(drv_en)
  );

  typedef struct { logic [7:0] exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic compare(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value for every read cycle
  always @(negedge clk) begin
    if (rst_n && bus_sel && !bus_wr) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R8: unexpected read, actual 0x%02h expected none", bus_rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        compare(bus_rdata, it.exp, it.tag);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic pulse(input logic [7:0] m);
    ev = m; tick(); ev = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    tick();
    bus_sel = 0;
  endtask

  task automatic chk_en(input logic exp, input string tag);
    #1;
    compare({7'd0, drv_en}, {7'd0, exp}, tag);
  endtask

  task automatic cycle_req();
    drv_en_req = 0; tick(); drv_en_req = 1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    tick();
    rd(0, 8'h01, "R1 reset value");
    chk_en(0, "R1 enable off with request low");
    drv_en_req = 1;
    chk_en(1, "R10 enable follows request");

    wr(0, 8'h01);
    rd(0, 8'h00, "R3 clear por flag");

    pulse(8'h80);
    rd(0, 8'h80, "R2 osc flag bit7");
    pulse(8'h04); pulse(8'h02);
    rd(0, 8'h86, "R2 watchdog flags bits2,1");
    chk_en(1, "R10 non-fault flags leave drivers on");

    wr(0, 8'h00);
    rd(0, 8'h86, "R3 zero write keeps");
    wr(0, 8'h04);
    rd(0, 8'h82, "R3 clear bit2 only");

    pulse(8'h20);
    chk_en(1, "R6 ov unprotected no shutdown");
    pulse(8'h10);
    chk_en(1, "R6 uv unprotected no shutdown");
    rd(0, 8'hB2, "R2 ov and uv flags");

    rd(1, 8'h00, "R8 other address reads zero");
    wr(3, 8'hFF);
    rd(0, 8'hB2, "R8 write elsewhere ignored");
    rd(0, 8'hB2, "R8 read has no side effect");

    ev = 8'h80; bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h80;
    tick();
    ev = '0; bus_sel = 0; bus_wr = 0;
    rd(0, 8'hB2, "R4 set beats clear");

    wr(0, 8'hFF);
    rd(0, 8'h00, "R3 clear all");

    pulse(8'h40);
    chk_en(0, "R5 charge pump shutdown");
    rd(0, 8'h40, "R2 cp flag bit6");
    cycle_req();
    chk_en(0, "R7 request toggle with flag set stays off");
    wr(0, 8'h40);
    chk_en(0, "R7 flag cleared but request not toggled");
    cycle_req();
    chk_en(1, "R7 release after clear and toggle");

    ov_prot_en = 1;
    pulse(8'h08);
    chk_en(0, "R5 over-temperature shutdown");
    wr(0, 8'h08); cycle_req();
    chk_en(1, "R7 release after ot");

    pulse(8'h20);
    chk_en(0, "R6 ov protected shutdown");
    wr(0, 8'h20); cycle_req();
    chk_en(1, "R7 release after ov");
    ov_prot_en = 0; uv_prot_en = 1;
    pulse(8'h10);
    chk_en(0, "R6 uv protected shutdown");
    wr(0, 8'h10); cycle_req();
    chk_en(1, "R7 release after uv");
    uv_prot_en = 0;

    drv_en_req = 0;
    pulse(8'h40);
    drv_en_req = 1;
    chk_en(0, "R5 cp error while enabling");
    wr(0, 8'h40); cycle_req();
    chk_en(1, "R7 release after enabling trip");

    pulse(8'hA7);
    rd(0, 8'hA7, "R2 mixed flags");
    warm_rst_n = 0; tick(); warm_rst_n = 1;
    rd(0, 8'h05, "R9 warm reset keeps bits 2 and 0");

    drv_en_req = 0;
    chk_en(0, "R10 request low");

    tick();
    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R8: actual %0d pending reads expected 0", sb_q.size());
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule